// File: doc/BRIEF.md
# Byte-Wide Static RAM with Single-Error Correction

This block models a byte-wide static RAM whose storage cells hold a Hamming codeword instead of the bare byte. Every byte written is extended with four check bits and kept as a 12-bit word. On every read the stored word is decoded, one flipped bit is repaired, and the repaired byte goes out. A separate flag output goes high while a repaired word is being read, so a host can log the event. The repaired word is never copied back into the cell, so the fault stays in place until the location is written again.

The access controls follow the usual asynchronous SRAM convention: two chip selects of opposite polarity, an active-low write strobe and an active-low output enable. The bidirectional data bus is split into an input, an output and an output-enable, and the pad drivers sit outside the block. Writes are captured on the rising clock edge. Reads are combinational from the addressed cell. A test-only port flips one stored bit so that the repair path can be exercised. The data path has no flow control. Each access completes in one cycle and cannot be stalled, so the valid/ready convention does not apply here.

Top module: `ecc_sram`

## Requirements
- R1: With `cs_n` low, `cs` high and `wr_n` low, the byte on `dq_i` is stored at `addr` on the rising clock edge.
- R2: With `cs_n` low, `cs` high, `rd_n` low and `wr_n` high, `dq_oe` is 1 and `dq_o` carries the byte stored at `addr` in the same cycle.
- R3: `dq_oe` is 0 and `dq_o` is 0 whenever `cs_n` is high, `cs` is low, `rd_n` is high, or `wr_n` is low.
- R4: A write strobe given while the chip is deselected (`cs_n` high or `cs` low) leaves the addressed location unchanged.
- R5: A single flipped bit at any of the 12 codeword positions is corrected on read. The layout uses positions p = 1..12, with check bits at 1, 2, 4 and 8 and data bits d0..d7 at 3, 5, 6, 7, 9, 10, 11 and 12. The storage bit index is p-1.
- R6: `ecc_err` is 1 while a word holding one flipped bit is being read, and 0 while a clean word is being read.
- R7: `ecc_err` is 0 whenever no read is active, which includes writes and deselected cycles.
- R8: A corrected word is not written back. Repeated reads of it keep raising `ecc_err`, and a new write to that location clears the fault.
- R9: While `flip_en` is 1, the rising edge inverts storage bit `flip_bit` of the word at `flip_addr`. A `flip_bit` value above 11 does nothing. When a write targets the same address in the same cycle, the write wins.
- R10: While `rst_n` is low, writes and bit flips are ignored, and stored contents are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; writes and flips occur on its rising edge |
| rst_n | input | 1 | Active-low reset; blocks array updates |
| cs_n | input | 1 | Active-low chip select |
| cs | input | 1 | Active-high chip select |
| wr_n | input | 1 | Active-low write strobe |
| rd_n | input | 1 | Active-low output enable |
| addr | input | ADDR_W | Word address |
| dq_i | input | 8 | Write data from the pad |
| dq_o | output | 8 | Corrected read data to the pad |
| dq_oe | output | 1 | Pad driver enable |
| ecc_err | output | 1 | High while a corrected word is read |
| flip_en | input | 1 | Test-only: enable a stored-bit flip |
| flip_addr | input | ADDR_W | Test-only: word to corrupt |
| flip_bit | input | 4 | Test-only: storage bit index 0..11 |

## Verification
Random writes and reads over a small set of addresses check that data comes back unchanged and that clean words never raise the flag. Flips placed at random positions, including the four check-bit positions, separate correction of data bits from correction of check bits, and show whether the flag follows only the faulty words. Directed cases then drive each control pin to its inactive level, issue strobes while deselected or in reset, use an out-of-range flip index, and collide a flip with a write at the same address. Each of these cases isolates one gating term. Re-reading a faulty word, and then overwriting it, shows that the fault is kept until the next write.

// File: rtl/ecc_sram_pkg.sv
package ecc_sram_pkg;
  localparam int DATA_W = 8;
  localparam int CHK_W  = 4;
  localparam int CW_W   = DATA_W + CHK_W;

  typedef logic [DATA_W-1:0] byte_t;
  typedef logic [CW_W-1:0]   cw_t;
  typedef logic [CHK_W-1:0]  syn_t;

  function automatic logic is_pow2(input int p);
    return (p & (p - 1)) == 0;
  endfunction

  // position-weighted xor over the whole codeword
  function automatic syn_t syndrome_of(input cw_t c);
    syn_t s = '0;
    for (int p = 1; p <= CW_W; p++)
      if (c[p-1]) s ^= syn_t'(p);
    return s;
  endfunction

  function automatic cw_t place_data(input byte_t d);
    cw_t c = '0;
    int k = 0;
    for (int p = 1; p <= CW_W; p++)
      if (!is_pow2(p)) begin
        c[p-1] = d[k];
        k++;
      end
    return c;
  endfunction

  function automatic byte_t pick_data(input cw_t c);
    byte_t d = '0;
    int k = 0;
    for (int p = 1; p <= CW_W; p++)
      if (!is_pow2(p)) begin
        d[k] = c[p-1];
        k++;
      end
    return d;
  endfunction
endpackage

// File: rtl/ecc_encoder.sv
module ecc_encoder
  import ecc_sram_pkg::*;
(
  input  byte_t data,
  output cw_t   word
);
  cw_t  spread;
  syn_t chk;

  always_comb begin
    spread = place_data(data);
    chk    = syndrome_of(spread);
    word   = spread;
    for (int k = 0; k < CHK_W; k++)
      word[(1 << k) - 1] = chk[k];
  end

  // R5: every word leaving the encoder must decode as clean
  always_comb begin
    clean_word_chk: assert (syndrome_of(word) == '0);
  end
endmodule

// File: rtl/ecc_decoder.sv
module ecc_decoder
  import ecc_sram_pkg::*;
(
  input  cw_t   word,
  output byte_t data,
  output logic  fault
);
  syn_t syn;
  cw_t  fixed;

  always_comb begin
    syn   = syndrome_of(word);
    fixed = word;
    if (syn != '0 && int'(syn) <= CW_W)
      fixed[syn - 1'b1] = ~word[syn - 1'b1];
    data  = pick_data(fixed);
    fault = (syn != '0);
  end

  // R5: a repaired word must itself decode as clean
  always_comb begin
    repair_clean_chk: assert (!(fault && int'(syn) <= CW_W) || syndrome_of(fixed) == '0);
  end
endmodule

// File: rtl/ecc_store.sv
module ecc_store
  import ecc_sram_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  cw_t               wr_word,
  input  logic              flip_en,
  input  logic [ADDR_W-1:0] flip_addr,
  input  logic [3:0]        flip_bit,
  input  logic [ADDR_W-1:0] rd_addr,
  output cw_t               rd_word
);
  localparam int DEPTH = 1 << ADDR_W;

  cw_t  cells [DEPTH];
  logic flip_ok;

  assign flip_ok = flip_en && (int'(flip_bit) < CW_W) &&
                   !(wr_en && wr_addr == flip_addr);

  always_ff @(posedge clk) begin
    if (rst_n) begin
      if (flip_ok)
        cells[flip_addr][flip_bit] <= ~cells[flip_addr][flip_bit];
      if (wr_en)
        cells[wr_addr] <= wr_word;
    end
  end

  assign rd_word = cells[rd_addr];

  // R1
  wr_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> cells[$past(wr_addr)] == $past(wr_word));
endmodule

// File: rtl/ecc_sram.sv
module ecc_sram
  import ecc_sram_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              cs,
  input  logic              wr_n,
  input  logic              rd_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        dq_i,
  output logic [7:0]        dq_o,
  output logic              dq_oe,
  output logic              ecc_err,
  input  logic              flip_en,
  input  logic [ADDR_W-1:0] flip_addr,
  input  logic [3:0]        flip_bit
);
  logic  selected, wr_act, rd_act, fault;
  cw_t   enc_word, stored;
  byte_t rd_data;

  assign selected = !cs_n && cs;
  assign wr_act   = selected && !wr_n;
  assign rd_act   = selected && wr_n && !rd_n;

  ecc_encoder u_enc (.data(dq_i), .word(enc_word));

  ecc_store #(.ADDR_W(ADDR_W)) u_store (
    .clk, .rst_n,
    .wr_en(wr_act), .wr_addr(addr), .wr_word(enc_word),
    .flip_en, .flip_addr, .flip_bit,
    .rd_addr(addr), .rd_word(stored)
  );

  ecc_decoder u_dec (.word(stored), .data(rd_data), .fault(fault));

  assign dq_oe   = rd_act;
  assign dq_o    = rd_act ? rd_data : '0;
  assign ecc_err = rd_act && fault;

  // R7
  err_needs_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ecc_err |-> dq_oe);
  // R3
  quiet_on_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_n |-> !dq_oe && !ecc_err && dq_o == '0);
endmodule

// File: tb/test_ecc_sram.sv
module test_ecc_sram;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 10;

  logic clk = 0, rst_n = 0;
  logic cs_n = 1, cs = 0, wr_n = 1, rd_n = 1;
  logic [AW-1:0] addr = '0, flip_addr = '0;
  logic [7:0] dq_i = '0;
  logic flip_en = 0;
  logic [3:0] flip_bit = '0;
  logic [7:0] dq_o;
  logic dq_oe, ecc_err;

  int checks = 0, fails = 0;
  bit done = 0;

  byte unsigned model [16];
  int  flips [16];
  bit  valid [16];

  always #(CLK_PERIOD/2) clk = ~clk;

  ecc_sram #(.ADDR_W(AW)) i_ecc_sram (.*);

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic idle();
    cs_n = 1; cs = 0; wr_n = 1; rd_n = 1; flip_en = 0;
  endtask

  // pool index i maps to address i*37
  function automatic logic [AW-1:0] ad(input int i);
    return AW'(i * 37);
  endfunction

  task automatic wr(input int i, input byte unsigned d);
    @(negedge clk);
    cs_n = 0; cs = 1; wr_n = 0; rd_n = 1; addr = ad(i); dq_i = d;
    @(negedge clk);
    idle();
    if (rst_n) begin model[i] = d; flips[i] = 0; valid[i] = 1; end
  endtask

  task automatic flip(input int i, input int b);
    @(negedge clk);
    flip_en = 1; flip_addr = ad(i); flip_bit = 4'(b);
    @(negedge clk);
    flip_en = 0;
    if (rst_n && b < 12) flips[i]++;
  endtask

  task automatic rd(input int i, input string req);
    @(negedge clk);
    cs_n = 0; cs = 1; wr_n = 1; rd_n = 0; addr = ad(i);
    #1;
    chk({req, " oe"}, dq_oe, 1);
    chk({req, " data"}, dq_o, model[i]);
    chk({req, " err"}, ecc_err, flips[i] == 1);
    idle();
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not end");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 16; i++) begin valid[i] = 0; flips[i] = 0; model[i] = 0; end
    repeat (3) @(negedge clk);
    #1;
    chk("R3 reset oe", dq_oe, 0);
    chk("R7 reset err", ecc_err, 0);
    rst_n = 1;

    // R10: updates blocked in reset
    wr(5, 8'h3C);
    @(negedge clk); rst_n = 0;
    wr(5, 8'hFF);
    flip(5, 2);
    @(negedge clk); rst_n = 1;
    rd(5, "R10");

    // R1 R2 directed patterns
    wr(0, 8'h00); rd(0, "R2 zeros");
    wr(1, 8'hFF); rd(1, "R1 ones");
    wr(2, 8'hA5); rd(2, "R2 mix");

    // R5 R6: every position, check bits included
    for (int b = 0; b < 12; b++) begin
      wr(3, 8'(8'h5A ^ b));
      flip(3, b);
      rd(3, "R5 pos");
    end

    // R8: kept after read, cleared by rewrite
    flip(2, 6);
    rd(2, "R8 first");
    rd(2, "R8 again");
    wr(2, 8'hC3);
    rd(2, "R8 rewrite");

    // R9: out-of-range index, and write priority
    flip(1, 13);
    rd(1, "R9 range");
    @(negedge clk);
    cs_n = 0; cs = 1; wr_n = 0; addr = ad(0); dq_i = 8'h77;
    flip_en = 1; flip_addr = ad(0); flip_bit = 4'd4;
    @(negedge clk); idle();
    model[0] = 8'h77; flips[0] = 0;
    rd(0, "R9 collide");

    // R4: strobes while deselected
    @(negedge clk);
    cs_n = 1; cs = 1; wr_n = 0; addr = ad(1); dq_i = 8'h11;
    @(negedge clk);
    cs_n = 0; cs = 0;
    @(negedge clk); idle();
    rd(1, "R4");

    // R3 R7: no drive without a full read, flag quiet on a faulty word
    flip(2, 9);
    @(negedge clk); addr = ad(2);
    cs_n = 0; cs = 1; wr_n = 1; rd_n = 1; #1;
    chk("R3 rd_n high", dq_oe, 0); chk("R7 rd_n high", ecc_err, 0);
    cs_n = 1; rd_n = 0; #1;
    chk("R3 cs_n high", dq_oe, 0); chk("R7 cs_n high", ecc_err, 0);
    cs_n = 0; cs = 0; #1;
    chk("R3 cs low", dq_oe, 0); chk("R3 cs low data", dq_o, 0);
    idle();
    rd(2, "R6 faulty");

    // random mix
    void'($urandom(32'd2024));
    for (int n = 0; n < 400; n++) begin
      int i;
      int op;
      i = int'($urandom_range(0, 15));
      op = int'($urandom_range(0, 9));
      if (op < 4 || !valid[i]) wr(i, 8'($urandom));
      else if (op < 8) rd(i, "R2 R6 random");
      else if (flips[i] == 0) flip(i, int'($urandom_range(0, 11)));
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule